// File: doc/BRIEF.md
# Multichannel Alarm Interrupt Aggregator

This block gathers alarm conditions from twelve line channels and folds them into one active-low interrupt for a host. Each channel delivers six raw alarm levels. The block brings them into its clock domain and derives a seventh condition, receive loss of signal, as the OR of the analog and digital loss detectors. An interrupt event is recorded on every change of any condition, whether the condition appears or goes away.

Events are kept at two levels. At the source level, each channel has an enable mask, a sticky event register that clears when it is read, and a view of the live alarm levels. At the channel level, the twelve channels form two groups of six. Each group has a channel-enable register and a pending register with one bit per channel. The host reads a group's pending register to find the channel that raised the interrupt. It then reads that channel's event register to find the cause and to clear it. Access is through a simple register port with a read strobe and a write strobe. Read data is registered, so it is valid on the cycle after the strobe.

Top module: `irqAggregator`

## Requirements
- R1: The live alarm register of a channel (field 2) shows the synchronised current levels with this layout: bit0 transmit drive fault, bit1 receive LOS, bit2 loss of lock, bit3 FIFO limit, bit4 analog LOS, bit5 digital LOS, bit6 loss of PRBS lock. The raw input bits of a channel, from 0 to 5, are transmit drive fault, loss of lock, FIFO limit, analog LOS, digital LOS and PRBS lock loss. Receive LOS equals analog LOS OR digital LOS.
- R2: Every rising and every falling transition of a live alarm bit sets the matching bit of that channel's event register (field 1), provided the matching source-enable bit (field 0) is set. The bit stays set until it is cleared.
- R3: A read of a channel's event register returns the latched bits and clears them.
- R4: If a new event arrives in the same cycle as a read of the event register, the read returns only the older bits, and the new event stays latched afterwards.
- R5: A transition on a source whose enable bit is clear does not set the event register and does not drive the interrupt.
- R6: The group pending registers are at 0x61 (channels 0 to 5) and 0xE1 (channels 6 to 11). Bit k is set when channel group*6+k has any latched event bit, whatever its channel enable.
- R7: irqN is low exactly when some channel has a latched event and its bit is set in the group enable register (0x60 or 0xE0). Once low, it stays low until the event is cleared or the channel enable is removed.
- R8: Per-channel registers are at address {group, local channel[2:0], field[3:0]}. The enable registers read back what was written. Writes to the event, live and pending registers have no effect.
- R9: A synchronous reset clears all enables and latched events, and irqN is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarmRaw | input | 72 | Raw alarm levels, six bits per channel, channel c at bits [6c+5:6c] |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regWr | input | 1 | Write strobe, one cycle |
| regRd | input | 1 | Read strobe, one cycle |
| regRdData | output | 8 | Read data, registered on the strobe edge |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The hard case is a new alarm event that is latched on the same clock edge as a host read that clears the event register. The bench changes a raw alarm bit a known two cycles before it raises the read strobe. It then checks two things: the read returns only the previously latched bit, and a second read returns the new event alone. The checker also examines every read-clear cycle in which an event is present, to confirm that the event survives the clear.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int NUM_CH   = 12;
  localparam int GRP_SIZE = 6;
  localparam int NUM_GRP  = NUM_CH / GRP_SIZE;
  localparam int RAW_W    = 6;
  localparam int AL_W     = RAW_W + 1;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int FLD_W    = 4;
  localparam int LOC_LSB  = FLD_W;
  localparam int LOC_W    = 3;
  localparam int GRP_LSB  = LOC_LSB + LOC_W;
  localparam int GRP_W    = ADDR_W - GRP_LSB;

  localparam logic [FLD_W-1:0] FLD_EN   = 4'd0;
  localparam logic [FLD_W-1:0] FLD_ST   = 4'd1;
  localparam logic [FLD_W-1:0] FLD_LIVE = 4'd2;

  // raw input bit positions
  localparam int RAW_TXF  = 0;
  localparam int RAW_LOL  = 1;
  localparam int RAW_FIFO = 2;
  localparam int RAW_ALOS = 3;
  localparam int RAW_DLOS = 4;
  localparam int RAW_PRBS = 5;

  typedef enum logic [2:0] {
    RS_NONE, RS_SRC_EN, RS_SRC_ST, RS_LIVE, RS_GRP_EN, RS_GRP_ST
  } regSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0]  srcEnWr;
    logic [NUM_CH-1:0]  stClr;
    logic [NUM_GRP-1:0] grpEnWr;
    regSel_e            rdSel;
    logic [CH_W-1:0]    ch;
    logic [GRP_W-1:0]   grp;
    logic               rdStb;
  } strobe_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output strobe_t           stb
);
  logic [GRP_W-1:0] grp;
  logic [LOC_W-1:0] loc;
  logic [FLD_W-1:0] fld;
  int               chIdx;
  logic             chValid;
  logic             grpLevel;

  always_comb begin
    grp      = regAddr[ADDR_W-1:GRP_LSB];
    loc      = regAddr[GRP_LSB-1:LOC_LSB];
    fld      = regAddr[FLD_W-1:0];
    chIdx    = int'(grp) * GRP_SIZE + int'(loc);
    chValid  = (int'(loc) < GRP_SIZE) && (chIdx < NUM_CH);
    grpLevel = (int'(loc) == GRP_SIZE) && (int'(grp) < NUM_GRP);

    stb        = '0;
    stb.rdStb  = regRd;
    stb.grp    = grp;
    stb.ch     = CH_W'(chIdx);
    stb.rdSel  = RS_NONE;

    if (chValid) begin
      case (fld)
        FLD_EN:   stb.rdSel = RS_SRC_EN;
        FLD_ST:   stb.rdSel = RS_SRC_ST;
        FLD_LIVE: stb.rdSel = RS_LIVE;
        default:  stb.rdSel = RS_NONE;
      endcase
      if (regWr && fld == FLD_EN) stb.srcEnWr[chIdx] = 1'b1;
      if (regRd && fld == FLD_ST) stb.stClr[chIdx]   = 1'b1;
    end else if (grpLevel) begin
      case (fld)
        FLD_EN:  stb.rdSel = RS_GRP_EN;
        FLD_ST:  stb.rdSel = RS_GRP_ST;
        default: stb.rdSel = RS_NONE;
      endcase
      if (regWr && fld == FLD_EN) stb.grpEnWr[grp] = 1'b1;
    end
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH*RAW_W-1:0]       alarmRaw,
  input  logic [DATA_W-1:0]             regWrData,
  input  strobe_t                       stb,
  output logic [DATA_W-1:0]             regRdData,
  output logic                          irqN,
  output logic [NUM_CH-1:0][AL_W-1:0]   srcStAll,
  output logic [NUM_CH-1:0][AL_W-1:0]   srcEnAll,
  output logic [NUM_CH-1:0][AL_W-1:0]   evtAll
);
  logic [NUM_CH-1:0][AL_W-1:0]      liveAl;
  logic [NUM_CH-1:0]                chPend;
  logic [NUM_GRP-1:0][GRP_SIZE-1:0] grpEn;
  logic [NUM_CH-1:0]                grpEnFlat;

  function automatic logic [AL_W-1:0] mapLive(input logic [RAW_W-1:0] r);
    mapLive = {r[RAW_PRBS], r[RAW_DLOS], r[RAW_ALOS], r[RAW_FIFO],
               r[RAW_LOL], r[RAW_ALOS] | r[RAW_DLOS], r[RAW_TXF]};
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0][RAW_W-1:0] syncQ;
    logic [AL_W-1:0]                   prevQ;
    logic [AL_W-1:0]                   srcEn;
    logic [AL_W-1:0]                   srcSt;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '0;
        prevQ <= '0;
      end else begin
        syncQ[0] <= alarmRaw[c*RAW_W +: RAW_W];
        for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
        prevQ <= liveAl[c];
      end
    end

    assign liveAl[c] = mapLive(syncQ[SYNC_STAGES-1]);
    assign evtAll[c] = (liveAl[c] ^ prevQ) & srcEn;

    always_ff @(posedge clk) begin
      if (rst) begin
        srcEn <= '0;
        srcSt <= '0;
      end else begin
        if (stb.srcEnWr[c]) srcEn <= regWrData[AL_W-1:0];
        srcSt <= (srcSt & ~{AL_W{stb.stClr[c]}}) | evtAll[c];
      end
    end

    assign srcStAll[c] = srcSt;
    assign srcEnAll[c] = srcEn;
    assign chPend[c]   = |srcSt;
  end

  always_ff @(posedge clk) begin
    if (rst) grpEn <= '0;
    else
      for (int g = 0; g < NUM_GRP; g++)
        if (stb.grpEnWr[g]) grpEn[g] <= regWrData[GRP_SIZE-1:0];
  end

  assign grpEnFlat = grpEn;
  assign irqN      = ~|(chPend & grpEnFlat);

  logic [DATA_W-1:0] rdVal;
  always_comb begin
    rdVal = '0;
    case (stb.rdSel)
      RS_SRC_EN: rdVal[AL_W-1:0]     = srcEnAll[stb.ch];
      RS_SRC_ST: rdVal[AL_W-1:0]     = srcStAll[stb.ch];
      RS_LIVE:   rdVal[AL_W-1:0]     = liveAl[stb.ch];
      RS_GRP_EN: rdVal[GRP_SIZE-1:0] = grpEn[stb.grp];
      RS_GRP_ST: rdVal[GRP_SIZE-1:0] = chPend[int'(stb.grp)*GRP_SIZE +: GRP_SIZE];
      default:   rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) regRdData <= '0;
    else if (stb.rdStb) regRdData <= rdVal;
  end
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggPkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*RAW_W-1:0] alarmRaw,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic                    regWr,
  input  logic                    regRd,
  output logic [DATA_W-1:0]       regRdData,
  output logic                    irqN
);
  strobe_t                     stb;
  logic [NUM_CH-1:0][AL_W-1:0] srcStAll;
  logic [NUM_CH-1:0][AL_W-1:0] srcEnAll;
  logic [NUM_CH-1:0][AL_W-1:0] evtAll;

  irqAggCtrl u_ctrl (
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .stb     (stb)
  );

  irqAggDatapath #(.SYNC_STAGES(2)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .alarmRaw  (alarmRaw),
    .regWrData (regWrData),
    .stb       (stb),
    .regRdData (regRdData),
    .irqN      (irqN),
    .srcStAll  (srcStAll),
    .srcEnAll  (srcEnAll),
    .evtAll    (evtAll)
  );
endmodule

// File: rtl/irqAggChecker.sv
module irqAggChecker
  import irqAggPkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        irqN,
  input strobe_t                     stb,
  input logic [NUM_CH-1:0][AL_W-1:0] srcStAll,
  input logic [NUM_CH-1:0][AL_W-1:0] srcEnAll,
  input logic [NUM_CH-1:0][AL_W-1:0] evtAll
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_event_latch_r2: assert property (@(posedge clk) disable iff (rst)
      (evtAll[c] != '0) |=> ((srcStAll[c] & $past(evtAll[c])) == $past(evtAll[c])));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (stb.stClr[c] && evtAll[c] == '0) |=> (srcStAll[c] == '0));

    p_collision_kept_r4: assert property (@(posedge clk) disable iff (rst)
      (stb.stClr[c] && evtAll[c] != '0) |=> (srcStAll[c] == $past(evtAll[c])));

    p_masked_source_r5: assert property (@(posedge clk) disable iff (rst)
      (srcEnAll[c] != '1) |=>
        ((srcStAll[c] & ~$past(srcStAll[c]) & ~$past(srcEnAll[c])) == '0));
  end

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!irqN && stb.stClr == '0 && stb.grpEnWr == '0) |=> !irqN);

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irqN);
endmodule

bind irqAggregator irqAggChecker u_chk (.*);

// File: tb/test_irqAggregator.sv
module test_irqAggregator;
  import irqAggPkg::*;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NUM_CH*RAW_W-1:0] alarmRaw = '0;
  logic [ADDR_W-1:0]       regAddr = '0;
  logic [DATA_W-1:0]       regWrData = '0;
  logic                    regWr = 1'b0;
  logic                    regRd = 1'b0;
  logic [DATA_W-1:0]       regRdData;
  logic                    irqN;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irqAggregator i_irqAggregator (
    .clk (clk), .rst (rst), .alarmRaw (alarmRaw), .regAddr (regAddr),
    .regWrData (regWrData), .regWr (regWr), .regRd (regRd),
    .regRdData (regRdData), .irqN (irqN)
  );

  // {irqN expected, channel, raw value, read address, expected read data}
  localparam int NVEC = 11;
  localparam logic [35:0] VEC [NVEC] = '{
    36'h0_00_01_02_01,  // R1 transmit fault level, R7 irq low
    36'h0_00_01_01_01,  // R2 rise latched
    36'h1_00_01_01_00,  // R3 cleared by previous read
    36'h0_00_00_01_01,  // R2 fall latched
    36'h0_00_08_02_12,  // R1 analog LOS drives receive LOS
    36'h0_00_08_01_12,  // R2 two events
    36'h0_00_18_01_20,  // R1 receive LOS unchanged, only digital LOS event
    36'h0_00_10_01_10,  // R2 analog LOS clear
    36'h0_07_20_E1_02,  // R6 upper group pending bit1
    36'h0_07_20_91_40,  // R2 PRBS lock loss on channel 7
    36'h1_07_20_E1_00   // R6 pending gone, R7 irq high
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic setRaw(input int ch, input logic [RAW_W-1:0] v);
    alarmRaw[ch*RAW_W +: RAW_W] = v;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 irqN after reset", {7'd0, irqN}, 8'h01);
    regRead(8'h60, rd); check("R9 group enable after reset", rd, 8'h00);

    regWrite(8'h00, 8'h7F);
    regWrite(8'h90, 8'h7F);
    regWrite(8'h60, 8'h3F);
    regWrite(8'hE0, 8'h3F);

    for (int i = 0; i < NVEC; i++) begin
      setRaw(int'(VEC[i][31:24]), VEC[i][21:16]);
      settle();
      check("R7 irqN vector", {7'd0, irqN}, {7'd0, VEC[i][32]});
      regRead(VEC[i][15:8], rd);
      check("R1 R2 R3 R6 vector read", rd, VEC[i][7:0]);
    end

    // R8: enable readback, writes to read-only registers ignored
    regRead(8'h00, rd); check("R8 source enable readback", rd, 8'h7F);
    regWrite(8'h02, 8'hFF);
    regRead(8'h02, rd); check("R8 live register not writable", rd, 8'h22);
    regWrite(8'h61, 8'hFF);
    regRead(8'h61, rd); check("R8 pending register not writable", rd, 8'h00);
    regRead(8'h60, rd); check("R8 group enable readback", rd, 8'h3F);

    // R5: disabled source is ignored
    regWrite(8'h30, 8'h00);
    setRaw(3, 6'h01);
    settle();
    check("R5 irqN stays high", {7'd0, irqN}, 8'h01);
    regRead(8'h31, rd); check("R5 no latch when disabled", rd, 8'h00);

    // R7 / R6: channel-level enable gates the interrupt
    regWrite(8'h30, 8'h7F);
    regWrite(8'h60, 8'h37);
    setRaw(3, 6'h00);
    settle();
    check("R7 masked channel keeps irqN high", {7'd0, irqN}, 8'h01);
    regRead(8'h61, rd); check("R6 pending ignores channel enable", rd, 8'h08);
    regWrite(8'h60, 8'h3F);
    check("R7 enabling channel asserts irq", {7'd0, irqN}, 8'h00);
    regRead(8'h31, rd); check("R3 channel 3 event", rd, 8'h01);
    check("R7 irqN released after service", {7'd0, irqN}, 8'h01);

    // R4: new event on the same edge as the clearing read
    setRaw(0, 6'h11);
    settle();
    @(negedge clk);
    setRaw(0, 6'h13);
    @(negedge clk);
    @(negedge clk);
    regAddr = 8'h01; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    check("R4 read returns older event only", regRdData, 8'h01);
    check("R4 irqN still low", {7'd0, irqN}, 8'h00);
    regRead(8'h01, rd); check("R4 colliding event kept", rd, 8'h04);

    // R9: mid-run reset with pending event
    setRaw(0, 6'h10);
    settle();
    check("R9 irq pending before reset", {7'd0, irqN}, 8'h00);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 irqN high after reset", {7'd0, irqN}, 8'h01);
    regRead(8'h00, rd); check("R9 enable cleared", rd, 8'h00);
    regRead(8'h01, rd); check("R9 events cleared", rd, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule